// File: doc/BRIEF.md
# Split-Phase Card Clock Divider

This block derives a memory-card interface clock from a fast base clock. An 8-bit phase field gives the high phase and the low phase lengths separately, in base-clock cycles. Because the two lengths are set on their own, an odd total divide ratio is possible, and the duty cycle is then off by one base cycle. With a 208 MHz base, a field of 0x54 gives about 18.9 MHz (divide by 11), and 0x00 gives 104 MHz (divide by 2).

Software reaches the block through a small register port. It holds a 16-bit divisor register and a mode register. The mode register carries a feedback-clock select and a memory-stick frequency select. Two one-cycle prepare commands set up card or memory-stick operation in a single step. When the system enters its low-power performance state, the output follows an external reference clock (13 MHz) instead of the divider. A new phase field takes effect only when a complete low phase has finished, so the output never carries a truncated pulse.

Top module: `phase_split_clkdiv`

## Requirements
- R1: The output stays high for exactly (upper nibble of divisor bits 7:4) + 1 base-clock cycles in each period.
- R2: The output stays low for exactly (lower nibble of divisor bits 3:0) + 1 base-clock cycles in each period, so the period is the sum of the two phase lengths.
- R3: A phase field of 0x00 makes the output toggle on every base-clock cycle (divide by two).
- R4: While reset is held and after it is released, the output is low. The divisor register reads 0x0054 and the mode register reads 0x0000. The first periods use high 6 and low 5 cycles.
- R5: A divisor write takes effect at the first rising output edge that follows the end of a complete low phase. A write made during a high phase leaves that high phase and the following low phase at their old lengths.
- R6: All 16 bits of the divisor register (address 0) are written and read back. Bits 15:8 have no effect on the output waveform.
- R7: A card prepare (prep_req_i=1, prep_stick_i=0) sets divisor bits 7:0 to 0x54, keeps bits 15:8, and clears both mode bits.
- R8: A memory-stick prepare (prep_req_i=1, prep_stick_i=1) clears the feedback select, sets the frequency select and leaves the divisor unchanged.
- R9: While low_power_i is 1, clk_out_o equals ref_clk_i, whatever the divisor.
- R10: The mode register (address 1) holds the feedback select in bit 0 and the memory-stick frequency select in bit 1. Its other bits read as zero. fb_sel_o and ms_sel_o show bits 0 and 1.
- R11: Unequal nibbles give an asymmetric waveform. For example, 0x43 gives high 5 and low 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base_i | input | 1 | Base clock that drives the divider and the registers |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock used as the output in low-power mode |
| low_power_i | input | 1 | Selects the reference clock as the output |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wr_addr_i | input | 1 | Write address: 0 divisor, 1 mode |
| reg_wdata_i | input | 16 | Write data |
| reg_rd_addr_i | input | 1 | Read address: 0 divisor, 1 mode |
| reg_rdata_o | output | 16 | Read data for reg_rd_addr_i |
| prep_req_i | input | 1 | One-cycle prepare command |
| prep_stick_i | input | 1 | Prepare flavour: 0 card, 1 memory stick |
| clk_out_o | output | 1 | Divided or reference output clock |
| fb_sel_o | output | 1 | Feedback-clock select (mode bit 0) |
| ms_sel_o | output | 1 | Memory-stick frequency select (mode bit 1) |

## Verification
A wrong latched phase length shows on the output within one output period, as a high or low run of the wrong length. The bench measures both run lengths for every table entry. A load made at the wrong moment shows as a clipped or stretched phase right after a write. The bench catches this by recording the output cycle by cycle across a write placed inside a high phase. Wrong register or mode state shows at once on the read port and on the mode outputs. The low-power path is compared directly against the reference input.

// File: rtl/psd_pkg.sv
package psd_pkg;
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   localparam logic ADDR_DIV  = 1'b0;
   localparam logic ADDR_MODE = 1'b1;

   localparam int MODE_FB_BIT = 0;
   localparam int MODE_MS_BIT = 1;
   localparam int MODE_W      = 2;
endpackage

// File: rtl/psd_regs.sv
module psd_regs
   import psd_pkg::*;
#(
   parameter int          DIV_W    = 16,
   parameter int          SEL_W    = 8,
   parameter logic [7:0]  RST_SEL  = 8'h54,
   parameter logic [7:0]  PREP_SEL = 8'h54
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [DIV_W-1:0] wr_data,
   input  logic             rd_addr,
   output logic [DIV_W-1:0] rd_data,
   input  logic             prep_req,
   input  logic             prep_stick,
   output logic [SEL_W-1:0] div_sel,
   output logic             fb_sel,
   output logic             ms_sel
);
   localparam int UPPER_W = DIV_W - SEL_W;

   if (SEL_W > DIV_W) begin : g_bad_width
      $error("psd_regs: SEL_W must not exceed DIV_W");
   end
   if (SEL_W > 8) begin : g_bad_sel
      $error("psd_regs: SEL_W must fit the reset constants");
   end

   logic [DIV_W-1:0]  div_q;
   logic [MODE_W-1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= {{UPPER_W{1'b0}}, RST_SEL[SEL_W-1:0]};
         mode_q <= '0;
      end else if (prep_req) begin
         if (prep_stick) begin
            mode_q[MODE_FB_BIT] <= 1'b0;
            mode_q[MODE_MS_BIT] <= 1'b1;
         end else begin
            div_q[SEL_W-1:0] <= PREP_SEL[SEL_W-1:0];
            mode_q           <= '0;
         end
      end else if (wr_en) begin
         if (wr_addr == ADDR_DIV) begin
            div_q <= wr_data;
         end else begin
            mode_q <= wr_data[MODE_W-1:0];
         end
      end
   end

   always_comb begin
      if (rd_addr == ADDR_DIV) begin
         rd_data = div_q;
      end else begin
         rd_data = {{(DIV_W-MODE_W){1'b0}}, mode_q};
      end
   end

   assign div_sel = div_q[SEL_W-1:0];
   assign fb_sel  = mode_q[MODE_FB_BIT];
   assign ms_sel  = mode_q[MODE_MS_BIT];

   // R7: card prepare loads the default field and clears the mode
   assert_prep_card_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prep_req && !prep_stick) |=> (div_sel == PREP_SEL[SEL_W-1:0]) && !fb_sel && !ms_sel);

   // R8: memory-stick prepare sets only the frequency select and keeps the divisor
   assert_prep_stick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prep_req && prep_stick) |=> !fb_sel && ms_sel && $stable(div_q));
endmodule

// File: rtl/psd_phase_ctr.sv
module psd_phase_ctr
   import psd_pkg::*;
#(
   parameter int         NIB_W   = 4,
   parameter logic [7:0] RST_SEL = 8'h54
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*NIB_W-1:0] sel_in,
   output logic               div_q
);
   localparam int SEL_W = 2 * NIB_W;

   if (NIB_W < 1) begin : g_bad_nib
      $error("psd_phase_ctr: NIB_W must be at least 1");
   end

   phase_e           phase_q;
   logic [NIB_W-1:0] cnt_q;
   logic [NIB_W-1:0] hi_act_q;
   logic [NIB_W-1:0] lo_act_q;
   logic             hi_done;
   logic             lo_done;

   assign hi_done = (phase_q == PH_HIGH) && (cnt_q == hi_act_q);
   assign lo_done = (phase_q == PH_LOW)  && (cnt_q == lo_act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_LOW;
         cnt_q    <= '0;
         hi_act_q <= RST_SEL[SEL_W-1:NIB_W];
         lo_act_q <= RST_SEL[NIB_W-1:0];
      end else if (hi_done) begin
         phase_q <= PH_LOW;
         cnt_q   <= '0;
      end else if (lo_done) begin
         phase_q  <= PH_HIGH;
         cnt_q    <= '0;
         hi_act_q <= sel_in[SEL_W-1:NIB_W];
         lo_act_q <= sel_in[NIB_W-1:0];
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign div_q = (phase_q == PH_HIGH);

   // R1: the high-phase count never passes the latched high length
   assert_hi_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      div_q |-> (cnt_q <= hi_act_q));

   // R2: the low-phase count never passes the latched low length
   assert_lo_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !div_q |-> (cnt_q <= lo_act_q));

   // R5: latched lengths change only together with a rising output edge
   assert_load_point_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({hi_act_q, lo_act_q}) |-> $rose(div_q));
endmodule

// File: rtl/psd_out_sel.sv
module psd_out_sel #(
   parameter bit RETIME = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic div_in,
   input  logic ref_in,
   input  logic low_power,
   output logic clk_out
);
   logic div_int;

   if (RETIME) begin : g_retime
      logic div_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_r <= 1'b0;
         end else begin
            div_r <= div_in;
         end
      end
      assign div_int = div_r;
   end else begin : g_direct
      assign div_int = div_in;
   end

   assign clk_out = low_power ? ref_in : div_int;
endmodule

// File: rtl/phase_split_clkdiv.sv
module phase_split_clkdiv
   import psd_pkg::*;
#(
   parameter int         DIV_W    = 16,
   parameter int         NIB_W    = 4,
   parameter logic [7:0] RST_SEL  = 8'h54,
   parameter logic [7:0] PREP_SEL = 8'h54,
   parameter bit         RETIME   = 1'b1
) (
   input  logic             clk_base_i,
   input  logic             rst_n_i,
   input  logic             ref_clk_i,
   input  logic             low_power_i,
   input  logic             reg_wr_i,
   input  logic             reg_wr_addr_i,
   input  logic [DIV_W-1:0] reg_wdata_i,
   input  logic             reg_rd_addr_i,
   output logic [DIV_W-1:0] reg_rdata_o,
   input  logic             prep_req_i,
   input  logic             prep_stick_i,
   output logic             clk_out_o,
   output logic             fb_sel_o,
   output logic             ms_sel_o
);
   localparam int SEL_W = 2 * NIB_W;

   logic [SEL_W-1:0] div_sel;
   logic             div_raw;

   psd_regs #(
      .DIV_W    (DIV_W),
      .SEL_W    (SEL_W),
      .RST_SEL  (RST_SEL),
      .PREP_SEL (PREP_SEL)
   ) regs_i (
      .clk        (clk_base_i),
      .rst_n      (rst_n_i),
      .wr_en      (reg_wr_i),
      .wr_addr    (reg_wr_addr_i),
      .wr_data    (reg_wdata_i),
      .rd_addr    (reg_rd_addr_i),
      .rd_data    (reg_rdata_o),
      .prep_req   (prep_req_i),
      .prep_stick (prep_stick_i),
      .div_sel    (div_sel),
      .fb_sel     (fb_sel_o),
      .ms_sel     (ms_sel_o)
   );

   psd_phase_ctr #(
      .NIB_W   (NIB_W),
      .RST_SEL (RST_SEL)
   ) ctr_i (
      .clk    (clk_base_i),
      .rst_n  (rst_n_i),
      .sel_in (div_sel),
      .div_q  (div_raw)
   );

   psd_out_sel #(
      .RETIME (RETIME)
   ) out_i (
      .clk       (clk_base_i),
      .rst_n     (rst_n_i),
      .div_in    (div_raw),
      .ref_in    (ref_clk_i),
      .low_power (low_power_i),
      .clk_out   (clk_out_o)
   );

   // R4: the output is low in the first cycle after reset is released
   assert_reset_low_R4: assert property (@(posedge clk_base_i) disable iff (!rst_n_i)
      ($past(!rst_n_i) && !low_power_i) |-> !clk_out_o);
endmodule

// File: tb/phase_split_clkdiv_tb_top.sv
`timescale 1ns/1ps
module phase_split_clkdiv_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_clk = 1'b0;
   logic        low_power = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_wr_addr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        reg_rd_addr = 1'b0;
   logic [15:0] reg_rdata;
   logic        prep_req = 1'b0;
   logic        prep_stick = 1'b0;
   logic        clk_out;
   logic        fb_sel;
   logic        ms_sel;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   phase_split_clkdiv dut_i (
      .clk_base_i    (clk),
      .rst_n_i       (rst_n),
      .ref_clk_i     (ref_clk),
      .low_power_i   (low_power),
      .reg_wr_i      (reg_wr),
      .reg_wr_addr_i (reg_wr_addr),
      .reg_wdata_i   (reg_wdata),
      .reg_rd_addr_i (reg_rd_addr),
      .reg_rdata_o   (reg_rdata),
      .prep_req_i    (prep_req),
      .prep_stick_i  (prep_stick),
      .clk_out_o     (clk_out),
      .fb_sel_o      (fb_sel),
      .ms_sel_o      (ms_sel)
   );

   localparam int NVEC = 10;
   localparam logic [7:0] VEC_SEL [NVEC] = '{
      8'h54, 8'h44, 8'h43, 8'h33, 8'h32, 8'h22, 8'h21, 8'h11, 8'h00, 8'hF0
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic addr, input logic [15:0] data);
      @(negedge clk);
      reg_wr      = 1'b1;
      reg_wr_addr = addr;
      reg_wdata   = data;
      @(negedge clk);
      reg_wr      = 1'b0;
   endtask

   task automatic reg_read(input logic addr, output logic [15:0] data);
      @(negedge clk);
      reg_rd_addr = addr;
      #0.5;
      data = reg_rdata;
   endtask

   task automatic prepare(input logic stick);
      @(negedge clk);
      prep_req   = 1'b1;
      prep_stick = stick;
      @(negedge clk);
      prep_req   = 1'b0;
   endtask

   task automatic wait_rise();
      logic p;
      p = clk_out;
      forever begin
         @(negedge clk);
         if (!p && clk_out) break;
         p = clk_out;
      end
   endtask

   task automatic measure(output int hi, output int lo);
      wait_rise();
      hi = 1;
      forever begin
         @(negedge clk);
         if (clk_out) hi++;
         else break;
      end
      lo = 1;
      forever begin
         @(negedge clk);
         if (!clk_out) lo++;
         else break;
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      int hi, lo;
      logic [19:0] got, exp_pat;

      // R4: state during and after reset
      repeat (3) @(negedge clk);
      chk("R4 out in reset", int'(clk_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 out after reset", int'(clk_out), 0);
      reg_read(1'b0, rd);
      chk("R4 divisor reset", int'(rd), 16'h0054);
      reg_read(1'b1, rd);
      chk("R4 mode reset", int'(rd), 0);
      measure(hi, lo);
      chk("R4 reset high len", hi, 6);
      chk("R4 reset low len", lo, 5);

      // R1 R2 R3 R6 R11: table of phase fields with varied upper bytes
      for (int i = 0; i < NVEC; i++) begin
         logic [15:0] w;
         w = {8'hA5 ^ 8'(i * 37), VEC_SEL[i]};
         reg_write(1'b0, w);
         reg_read(1'b0, rd);
         chk("R6 divisor readback", int'(rd), int'(w));
         wait_rise();
         wait_rise();
         measure(hi, lo);
         chk("R1 high length", hi, int'(VEC_SEL[i][7:4]) + 1);
         chk("R2 low length", lo, int'(VEC_SEL[i][3:0]) + 1);
         if (VEC_SEL[i] == 8'h00) chk("R3 divide by two", hi + lo, 2);
         if (VEC_SEL[i] == 8'h43) chk("R11 asymmetric", hi - lo, 1);
      end

      // R5: write inside a high phase keeps current high and next low
      reg_write(1'b0, 16'h0011);
      wait_rise();
      wait_rise();
      wait_rise();
      got[0]      = clk_out;
      reg_wr      = 1'b1;
      reg_wr_addr = 1'b0;
      reg_wdata   = 16'h0077;
      for (int k = 1; k < 20; k++) begin
         @(negedge clk);
         if (k == 1) reg_wr = 1'b0;
         got[k] = clk_out;
      end
      exp_pat = '0;
      exp_pat[1:0]  = 2'b11;
      exp_pat[11:4] = 8'hFF;
      chk("R5 load after low phase", int'(got), int'(exp_pat));

      // R10: mode register fields
      reg_write(1'b1, 16'hFFFF);
      reg_read(1'b1, rd);
      chk("R10 mode readback", int'(rd), 3);
      chk("R10 fb/ms outputs", int'({ms_sel, fb_sel}), 3);
      reg_write(1'b1, 16'h0001);
      chk("R10 fb only", int'({ms_sel, fb_sel}), 1);

      // R8: memory-stick prepare
      reg_write(1'b0, 16'h3C21);
      prepare(1'b1);
      reg_read(1'b1, rd);
      chk("R8 mode after stick prepare", int'(rd), 2);
      reg_read(1'b0, rd);
      chk("R8 divisor unchanged", int'(rd), 16'h3C21);

      // R7: card prepare
      reg_write(1'b0, 16'hBE21);
      reg_write(1'b1, 16'h0003);
      prepare(1'b0);
      reg_read(1'b0, rd);
      chk("R7 divisor after card prepare", int'(rd), 16'hBE54);
      reg_read(1'b1, rd);
      chk("R7 mode cleared", int'(rd), 0);
      wait_rise();
      wait_rise();
      measure(hi, lo);
      chk("R7 high len", hi, 6);
      chk("R7 low len", lo, 5);

      // R9: low-power output follows reference
      reg_write(1'b0, 16'h0000);
      @(negedge clk);
      low_power = 1'b1;
      for (int k = 0; k < 6; k++) begin
         ref_clk = k[0];
         #0.5;
         chk("R9 follows reference", int'(clk_out), k & 1);
         @(negedge clk);
      end
      low_power = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule